// File: doc/BRIEF.md
# Dual Timer/Counter with Shared Mode Byte

Two up-counting timer/counters share one 8-bit mode byte and a small register bus. Each timer has a low count byte, a high count byte, a run bit and a sticky overflow flag. The mode nibble of each timer picks its counting shape, its count source and its gating. The count source is either the common `tick` strobe or falling edges on that timer's event pin. The gating is either the run bit alone or the run bit together with that timer's gate pin. The two overflow flags leave the block as the `ovf` outputs, so a separate interrupt controller can pick them up.

The mode field of each timer works as a state that selects the counting behaviour. The states are PRESCALE13 (`00`, a 13-bit count made of the high byte plus a 5-bit prescaler in the low byte), WIDE16 (`01`, a 16-bit count), RELOAD8 (`10`, the low byte reloads from the high byte) and SPLIT (`11`). The only transitions are bus writes to the mode byte, and any state can move to any other. SPLIT means something different for each timer. Timer 1 in SPLIT freezes. Timer 0 in SPLIT runs as two 8-bit counters, and its high half takes over timer 1's run bit and flag.

Software reads and writes the registers over the bus at these addresses:

| Address | Register |
|---|---|
| 0 | mode byte |
| 1 | control byte |
| 2 | timer 0 low byte |
| 3 | timer 0 high byte |
| 4 | timer 1 low byte |
| 5 | timer 1 high byte |

Reads are combinational. Writes take effect at the clock edge.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all six registers read 0 and both `ovf` outputs are low.
- R2: Each register reads back the value last written to it. Addresses 6 and 7 read 0. In the control byte, bit 0 is run0, bit 1 is run1, bit 2 is flag0 and bit 3 is flag1, and bits 7:4 read 0.
- R3: Mode byte bits 3:0 configure timer 0 and bits 7:4 configure timer 1. Within each nibble, bit 3 is the gate enable, bit 2 is the source select and bits 1:0 are the mode. With the gate enable set, a timer counts only while its run bit is 1 and its `gate_pin` bit is 1. With the gate enable clear, the run bit alone decides.
- R4: With source select 0, a timer advances once per clock in which `tick` is 1. With source select 1, it ignores `tick` and advances once per 1-to-0 transition of its `ev_pin` bit. The pin passes through a two-flop synchroniser, and the count changes on the third rising clock edge after the pin falls.
- R5: In mode 00, bits 4:0 of the low byte form a prescaler under the high byte, and bits 7:5 of the low byte are held. Counting past 1FFFh wraps to 0 and sets the flag.
- R6: In mode 01, the high and low bytes form one 16-bit count. Counting past FFFFh wraps to 0000h and sets the flag.
- R7: In mode 10, only the low byte counts. Counting past FFh loads the low byte from the high byte and sets the flag, and the high byte does not change.
- R8: An overflow flag stays set until software writes 0 to its bit in the control byte. A hardware set in the same clock takes priority over that write.
- R9: Timer 1 in mode 11 holds both of its count bytes.
- R10: With timer 0 in mode 11, its low byte is an 8-bit counter that uses timer 0's run bit, gating and source, and sets flag0 when it wraps. Its high byte is an 8-bit counter of `tick` that runs on run1 and sets flag1 when it wraps.
- R11: While timer 0 is in mode 11, timer 1 counts whatever its run1 bit says, still follows its own gate and source, and never sets flag1.
- R12: A bus write to a count byte beats an increment in the same clock. In modes 00 to 10, a write to either byte of a timer suppresses that timer's whole increment and its overflow for that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_we | input | 1 | write strobe |
| bus_addr | input | 3 | register address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data (combinational) |
| tick | input | 1 | internal count strobe |
| ev_pin | input | 2 | external event pins, bit i belongs to timer i |
| gate_pin | input | 2 | external gate pins, bit i belongs to timer i |
| ovf | output | 2 | overflow flags, bit i belongs to timer i |

## Verification
The hardest situation to reach from the ports is the split arrangement. In it, timer 0's high half runs on timer 1's run bit and sets flag1, while timer 1 carries on counting without its run bit and must never raise flag1. To get there, the stimulus first puts timer 0 in mode 11 with only run0 set, and shows that the high byte stays put while the low byte wraps. It then swaps the run bits, lets the high byte wrap into flag1, and finally switches timer 1 to 16 bits with run1 clear. Timer 1 is then driven across FFFFh, and flag1 must stay low the whole time. All counting is stepped one `tick` at a time, so every expected count is exact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;
    localparam int ADDR_W = 3;
    localparam int NUM_T  = 2;

    typedef enum logic [1:0] {
        MODE_PRESCALE13 = 2'b00,
        MODE_WIDE16     = 2'b01,
        MODE_RELOAD8    = 2'b10,
        MODE_SPLIT      = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      gate_en;
        logic      ext_src;
        tmr_mode_e mode;
    } tmr_cfg_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_MODE = 3'd0,
        RA_CTRL = 3'd1,
        RA_LO0  = 3'd2,
        RA_HI0  = 3'd3,
        RA_LO1  = 3'd4,
        RA_HI1  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin};
    end

    // last synchronised sample low, the one before it high
    assign fall = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              lo_en,
    input  logic              hi_en,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              lo_ovf,
    output logic              hi_ovf
);
    localparam int W2 = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_d, hi_d;
    logic [W2-1:0]     wide_sum;
    logic              any_wr;

    assign any_wr   = lo_wr | hi_wr;
    assign wide_sum = {hi_q, lo_q} + W2'(1);

    always_comb begin
        lo_d   = lo_q;
        hi_d   = hi_q;
        lo_ovf = 1'b0;
        hi_ovf = 1'b0;
        unique case (mode)
            MODE_PRESCALE13: begin
                if (lo_en && !any_wr) begin
                    if (lo_q[PRE_W-1:0] == '1) begin
                        lo_d[PRE_W-1:0] = '0;
                        hi_d            = hi_q + 1'b1;
                        lo_ovf          = (hi_q == '1);
                    end else begin
                        lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
                    end
                end
            end
            MODE_WIDE16: begin
                if (lo_en && !any_wr) begin
                    {hi_d, lo_d} = wide_sum;
                    lo_ovf       = ({hi_q, lo_q} == '1);
                end
            end
            MODE_RELOAD8: begin
                if (lo_en && !any_wr) begin
                    if (lo_q == '1) begin
                        lo_d   = hi_q;
                        lo_ovf = 1'b1;
                    end else begin
                        lo_d = lo_q + 1'b1;
                    end
                end
            end
            MODE_SPLIT: begin
                if (lo_en && !lo_wr) begin
                    lo_d   = lo_q + 1'b1;
                    lo_ovf = (lo_q == '1);
                end
                if (hi_en && !hi_wr) begin
                    hi_d   = hi_q + 1'b1;
                    hi_ovf = (hi_q == '1);
                end
            end
        endcase
        if (lo_wr) lo_d = wdata;
        if (hi_wr) hi_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick,
    input  logic [NUM_T-1:0]  ev_pin,
    input  logic [NUM_T-1:0]  gate_pin,
    output logic [NUM_T-1:0]  ovf
);
    localparam int NIB = BYTE_W / 2;

    logic [BYTE_W-1:0]             mode_q;
    logic [NUM_T-1:0]              run_q, flag_q, flag_set;
    tmr_cfg_t                      cfg [NUM_T];
    logic [NUM_T-1:0]              ev_fall, src_hit, qual;
    logic [NUM_T-1:0]              lo_en, hi_en, lo_wr, hi_wr;
    logic [NUM_T-1:0]              lo_ovf, hi_ovf;
    logic [NUM_T-1:0][BYTE_W-1:0]  lo_q, hi_q;
    logic                          t0_split, t1_split, ctrl_wr;

    always_comb begin
        cfg[0] = tmr_cfg_t'(mode_q[NIB-1:0]);
        cfg[1] = tmr_cfg_t'(mode_q[BYTE_W-1:NIB]);
    end

    assign t0_split = (cfg[0].mode == MODE_SPLIT);
    assign t1_split = (cfg[1].mode == MODE_SPLIT);
    assign ctrl_wr  = bus_we && (bus_addr == RA_CTRL);

    generate
        for (genvar i = 0; i < NUM_T; i++) begin : g_tmr
            tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (ev_pin[i]),
                .fall (ev_fall[i])
            );
            assign src_hit[i] = cfg[i].ext_src ? ev_fall[i] : tick;
            assign qual[i]    = ~cfg[i].gate_en | gate_pin[i];
            assign lo_wr[i]   = bus_we && (bus_addr == ADDR_W'(2 + 2 * i));
            assign hi_wr[i]   = bus_we && (bus_addr == ADDR_W'(3 + 2 * i));

            tmr_unit u_unit (
                .clk   (clk),
                .rst_n (rst_n),
                .mode  (cfg[i].mode),
                .lo_en (lo_en[i]),
                .hi_en (hi_en[i]),
                .lo_wr (lo_wr[i]),
                .hi_wr (hi_wr[i]),
                .wdata (bus_wdata),
                .lo_q  (lo_q[i]),
                .hi_q  (hi_q[i]),
                .lo_ovf(lo_ovf[i]),
                .hi_ovf(hi_ovf[i])
            );
        end
    endgenerate

    // count enables: timer 1 loses its run bit while timer 0 is split
    always_comb begin
        lo_en[0] = run_q[0] & qual[0] & src_hit[0];
        hi_en[0] = run_q[1] & tick;
        lo_en[1] = (t0_split | run_q[1]) & qual[1] & src_hit[1] & ~t1_split;
        hi_en[1] = 1'b0;
    end

    always_comb begin
        flag_set[0] = lo_ovf[0];
        flag_set[1] = t0_split ? hi_ovf[0] : (lo_ovf[1] | hi_ovf[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (bus_we && (bus_addr == RA_MODE)) mode_q <= bus_wdata;
            if (ctrl_wr) run_q <= bus_wdata[1:0];
            flag_q <= (ctrl_wr ? bus_wdata[3:2] : flag_q) | flag_set;
        end
    end

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_MODE: bus_rdata = mode_q;
            RA_CTRL: bus_rdata = {{(BYTE_W-4){1'b0}}, flag_q, run_q};
            RA_LO0:  bus_rdata = lo_q[0];
            RA_HI0:  bus_rdata = hi_q[0];
            RA_LO1:  bus_rdata = lo_q[1];
            RA_HI1:  bus_rdata = hi_q[1];
            default: bus_rdata = '0;
        endcase
    end

    assign ovf = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [1:0]       gate_pin,
    input logic [1:0]       ovf,
    input logic [7:0]       mode_q,
    input logic [1:0]       lo_en,
    input logic [1:0][7:0]  lo_q,
    input logic [1:0][7:0]  hi_q
);
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[0] && !(bus_we && bus_addr == 3'd1) |=> ovf[0]);

    assert_wide_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1:0] == 2'b01 && lo_en[0] && !bus_we && {hi_q[0], lo_q[0]} == 16'hFFFF
        |=> {hi_q[0], lo_q[0]} == 16'h0000 && ovf[0]);

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1:0] == 2'b10 && lo_en[0] && !bus_we && lo_q[0] == 8'hFF
        |=> lo_q[0] == $past(hi_q[0]) && $stable(hi_q[0]) && ovf[0]);

    assert_t1_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[5:4] == 2'b11 && !bus_we |=> $stable(lo_q[1]) && $stable(hi_q[1]));

    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[3] && !gate_pin[0] && mode_q[1:0] != 2'b11 && !bus_we
        |=> $stable(lo_q[0]) && $stable(hi_q[0]));

    assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == 3'd2 |=> lo_q[0] == $past(bus_wdata));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .gate_pin (gate_pin),
    .ovf      (ovf),
    .mode_q   (mode_q),
    .lo_en    (lo_en),
    .lo_q     (lo_q),
    .hi_q     (hi_q)
);

// File: tb/tmr_pair_test.sv
`timescale 1ns/1ps
module tmr_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick = 1'b0;
    logic [1:0] ev_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] ovf;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       rd_ev;

    always #4 clk = ~clk;

    tmr_pair uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .ev_pin(ev_pin), .gate_pin(gate_pin), .ovf(ovf)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, expv);
        end
    endtask

    // monitor: pops the expected item and compares with the read data
    initial forever begin
        @(rd_ev);
        begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        #1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> rd_ev;
        #1;
    endtask

    task automatic expect_ovf(input int i, input logic e, input string t);
        @(negedge clk);
        #1;
        check(t, {7'd0, ovf[i]}, {7'd0, e});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse(input int n);
        repeat (n) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ev_fall0();
        @(negedge clk); ev_pin[0] = 1'b1;
        repeat (3) @(negedge clk);
        ev_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) expect_rd(3'(a), 8'h00, "R1 reset reg");
        expect_ovf(0, 1'b0, "R1 ovf0");
        expect_ovf(1, 1'b0, "R1 ovf1");

        // R2 register access
        wr(3'd2, 8'hA5); wr(3'd3, 8'h3C); wr(3'd4, 8'h5A); wr(3'd5, 8'hC3);
        wr(3'd0, 8'h21); wr(3'd1, 8'h03);
        expect_rd(3'd2, 8'hA5, "R2 lo0");
        expect_rd(3'd3, 8'h3C, "R2 hi0");
        expect_rd(3'd4, 8'h5A, "R2 lo1");
        expect_rd(3'd5, 8'hC3, "R2 hi1");
        expect_rd(3'd0, 8'h21, "R2 mode");
        expect_rd(3'd1, 8'h03, "R2 ctrl");
        expect_rd(3'd6, 8'h00, "R2 unused addr");
        wr(3'd1, 8'h00);

        // R6 16-bit wrap
        wr(3'd0, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
        pulse(1);
        expect_ovf(0, 1'b0, "R6 no flag at FFFF");
        pulse(1);
        expect_rd(3'd2, 8'h00, "R6 lo wrap");
        expect_rd(3'd3, 8'h00, "R6 hi wrap");
        expect_ovf(0, 1'b1, "R6 flag");
        expect_rd(3'd1, 8'h05, "R2 ctrl flag0 bit");

        // R8 sticky flag
        pulse(3);
        expect_ovf(0, 1'b1, "R8 flag held");
        expect_rd(3'd2, 8'h03, "R8 count continues");
        wr(3'd1, 8'h01);
        expect_ovf(0, 1'b0, "R8 flag cleared");

        // R3 gating
        wr(3'd0, 8'h09);
        gate_pin[0] = 1'b0;
        pulse(4);
        expect_rd(3'd2, 8'h03, "R3 gate low holds");
        gate_pin[0] = 1'b1;
        pulse(2);
        expect_rd(3'd2, 8'h05, "R3 gate high counts");
        wr(3'd1, 8'h00);
        pulse(2);
        expect_rd(3'd2, 8'h05, "R3 run off holds");

        // R5 13-bit prescaled mode
        wr(3'd0, 8'h00); wr(3'd3, 8'hFF); wr(3'd2, 8'hFE); wr(3'd1, 8'h01);
        pulse(1);
        expect_rd(3'd2, 8'hFF, "R5 prescaler step");
        expect_ovf(0, 1'b0, "R5 no flag before wrap");
        pulse(1);
        expect_rd(3'd2, 8'hE0, "R5 lo wrap keeps upper bits");
        expect_rd(3'd3, 8'h00, "R5 hi wrap");
        expect_ovf(0, 1'b1, "R5 flag");

        // R7 auto reload
        wr(3'd0, 8'h02); wr(3'd3, 8'hFD); wr(3'd2, 8'hFE); wr(3'd1, 8'h01);
        pulse(1);
        expect_rd(3'd2, 8'hFF, "R7 step");
        pulse(1);
        expect_rd(3'd2, 8'hFD, "R7 reload");
        expect_rd(3'd3, 8'hFD, "R7 hi unchanged");
        expect_ovf(0, 1'b1, "R7 flag");
        pulse(1);
        expect_rd(3'd2, 8'hFE, "R7 counts from reload");

        // R4 external events
        wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
        ev_fall0(); ev_fall0(); ev_fall0();
        expect_rd(3'd2, 8'h03, "R4 three falls");
        pulse(5);
        expect_rd(3'd2, 8'h03, "R4 tick ignored");

        // R9 timer 1 frozen in mode 3
        wr(3'd0, 8'h30); wr(3'd4, 8'h10); wr(3'd1, 8'h02);
        pulse(4);
        expect_rd(3'd4, 8'h10, "R9 lo1 held");
        expect_rd(3'd5, 8'hC3, "R9 hi1 held");

        // R10 split timer 0
        wr(3'd0, 8'h03); wr(3'd2, 8'hFE); wr(3'd3, 8'hFE); wr(3'd1, 8'h01);
        pulse(2);
        expect_rd(3'd2, 8'h00, "R10 lo0 wrap");
        expect_rd(3'd3, 8'hFE, "R10 hi0 needs run1");
        expect_ovf(0, 1'b1, "R10 flag0");
        wr(3'd1, 8'h02);
        pulse(2);
        expect_rd(3'd3, 8'h00, "R10 hi0 wrap");
        expect_ovf(1, 1'b1, "R10 flag1 from hi0");
        expect_rd(3'd2, 8'h00, "R10 lo0 stopped");
        expect_rd(3'd1, 8'h0A, "R10 ctrl");

        // R11 timer 1 during split
        wr(3'd0, 8'h13); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF); wr(3'd1, 8'h00);
        pulse(3);
        expect_rd(3'd4, 8'h01, "R11 lo1 counts without run1");
        expect_rd(3'd5, 8'h00, "R11 hi1 wrapped");
        expect_ovf(1, 1'b0, "R11 no flag1");
        expect_rd(3'd3, 8'h00, "R11 hi0 idle");

        // R12 write beats increment
        wr(3'd0, 8'h01); wr(3'd3, 8'hFF); wr(3'd2, 8'hFF); wr(3'd1, 8'h01);
        @(negedge clk);
        tick = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h11;
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
        expect_rd(3'd2, 8'h11, "R12 write value");
        expect_rd(3'd3, 8'hFF, "R12 no carry");
        expect_ovf(0, 1'b0, "R12 no overflow");
        pulse(1);
        expect_rd(3'd2, 8'h12, "R12 counts after");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule